// File: doc/BRIEF.md
# Non-Blocking Load Miss Scoreboard

This block is the issue-control scoreboard of an in-order core that does not freeze on a cache miss. Every cycle it receives at most one instruction offered for issue and answers with a grant or a stall. A load that has missed in the cache is granted as long as a tracking slot is free. Its destination register is then flagged as waiting, and later instructions keep flowing. Several missing loads can therefore be in flight together, and their memory latencies overlap. An instruction stalls only when it reads a waiting register, or when it would overwrite a waiting register.

A fixed set of tracking slots records which register each outstanding load will fill. On a grant, the block reports the slot number given to the load; the memory side returns that number with the data. Returns may arrive in any order and are matched by slot number alone. An access that takes a translation miss is held until every tracking slot is empty, so that a fault on that access is reported after all older loads have finished.

Each slot is a two-state machine. SLOT_FREE moves to SLOT_WAIT on an allocation (transition ALLOC). SLOT_WAIT moves back to SLOT_FREE when a return names that slot (transition RELEASE). Reset forces every slot to SLOT_FREE (transition FLUSH). The issue decision is an enumeration that is evaluated afresh every cycle:
- DEC_IDLE: no request.
- DEC_SRC_HAZ: a source register is waiting.
- DEC_DST_HAZ: the destination register is waiting.
- DEC_FULL: the request is a load and no slot is free.
- DEC_XLAT_HOLD: the request is a translation-miss access and some slot is busy.
- DEC_GRANT: none of the above applies.

The checks are tested in the order listed. Only DEC_GRANT raises the grant.

Top module: `miss_scoreboard`

## Requirements
- R1: A synchronous active-high reset clears every waiting flag and frees every slot. After reset, any offered instruction is granted, and a load receives slot 0.
- R2: A load (`iss_load`=1, which always writes `iss_dst`) is granted when a slot is free. `iss_slot` reports the lowest-numbered free slot as a binary index. From the next cycle on, the destination register is waiting, and instructions that do not touch it keep being granted.
- R3: An instruction with an enabled source (`iss_src1_en` or `iss_src2_en` = 1) that names a waiting register is stalled (`iss_grant`=0).
- R4: An instruction that writes a waiting register (`iss_dst_en`=1, or a load) is stalled.
- R5: A second missing load is granted while an earlier one is still outstanding, up to NSLOT loads at once.
- R6: When all NSLOT slots are busy, a load is stalled, while a non-load instruction without hazards is still granted.
- R7: An access with `iss_xlat_miss`=1 is stalled while any slot is busy, and is granted once all slots are free.
- R8: A return (`ret_valid`=1) naming a busy slot clears that slot's register flag and frees the slot, both taking effect from the next cycle. An issue in the same cycle is decided on the state before the return.
- R9: Returns may come in any order; each return affects only the slot named by `ret_slot`.
- R10: A return naming a free slot is ignored: no flag changes and no slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_src1 | input | 5 | First source register index |
| iss_src1_en | input | 1 | First source is read |
| iss_src2 | input | 5 | Second source register index |
| iss_src2_en | input | 1 | Second source is read |
| iss_dst | input | 5 | Destination register index |
| iss_dst_en | input | 1 | Destination is written (a load always writes it) |
| iss_load | input | 1 | Instruction is a load that missed in the cache |
| iss_xlat_miss | input | 1 | Access took a translation miss |
| ret_valid | input | 1 | Load data returns this cycle |
| ret_slot | input | 3 | Slot number of the returning load |
| iss_grant | output | 1 | Offered instruction issues this cycle |
| iss_slot | output | 3 | Slot given to a granted load |

## Verification
The hardest situation to reach is a completely full slot table in which a release and a dependent request land in the same cycle, and the later reuse of exactly the freed slot. The stimulus first retires one load out of order and sends a return to an empty slot. It then fills the remaining seven slots with back-to-back loads. With the table full, it offers a load together with the return of slot 4. The load must stall in that cycle and receive slot 4 in the next cycle. Translation-miss accesses are offered both while slots are busy and after every slot has drained.

// File: rtl/miss_sb_pkg.sv
package miss_sb_pkg;

    typedef enum logic {
        SLOT_FREE,
        SLOT_WAIT
    } slot_state_t;

    typedef enum logic [2:0] {
        DEC_IDLE,
        DEC_SRC_HAZ,
        DEC_DST_HAZ,
        DEC_FULL,
        DEC_XLAT_HOLD,
        DEC_GRANT
    } issue_dec_t;

endpackage

// File: rtl/miss_sb_pending.sv
module miss_sb_pending #(
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [RW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [RW-1:0]   clr_idx,
    output logic [NREG-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            if (clr_en) pend[clr_idx] <= 1'b0;
            if (set_en) pend[set_idx] <= 1'b1;
        end
    end

    // R2: a granted load marks its destination
    p_set_marks_r2: assert property (@(posedge clk) disable iff (rst)
        set_en |=> pend[$past(set_idx)]);

    // R8: a release clears the destination flag
    p_clear_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !pend[$past(clr_idx)]);

endmodule

// File: rtl/miss_sb_slot.sv
module miss_sb_slot
    import miss_sb_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic [RW-1:0] alloc_dst,
    input  logic          release_i,
    output logic          busy,
    output logic [RW-1:0] dst
);

    slot_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_FREE: if (alloc)     state_nx = SLOT_WAIT;
            SLOT_WAIT: if (release_i) state_nx = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SLOT_FREE;
            dst   <= '0;
        end else begin
            state <= state_nx;
            if (alloc) dst <= alloc_dst;
        end
    end

    always_comb begin
        unique case (state)
            SLOT_FREE: busy = 1'b0;
            SLOT_WAIT: busy = 1'b1;
        endcase
    end

    // R5: only a free slot may be allocated
    p_alloc_free_r5: assert property (@(posedge clk) disable iff (rst)
        alloc |-> state == SLOT_FREE);

    // R8: a release returns the slot to free
    p_release_frees_r8: assert property (@(posedge clk) disable iff (rst)
        release_i |=> state == SLOT_FREE);

    // R10: a slot never released while free changes nothing
    p_free_stays_r10: assert property (@(posedge clk) disable iff (rst)
        (state == SLOT_FREE && !alloc) |=> state == SLOT_FREE);

endmodule

// File: rtl/miss_sb_issue.sv
module miss_sb_issue
    import miss_sb_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int NSLOT = 8,
    localparam int RW = $clog2(NREG),
    localparam int SW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [RW-1:0]    src1,
    input  logic             src1_en,
    input  logic [RW-1:0]    src2,
    input  logic             src2_en,
    input  logic [RW-1:0]    dst,
    input  logic             dst_en,
    input  logic             is_load,
    input  logic             xlat_miss,
    input  logic [NREG-1:0]  pend,
    input  logic [NSLOT-1:0] busy,
    output logic             grant,
    output logic             alloc_en,
    output logic [SW-1:0]    alloc_idx
);

    issue_dec_t dec;
    logic       free_found;
    logic       src_haz;
    logic       dst_haz;

    always_comb begin
        free_found = 1'b0;
        alloc_idx  = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_found = 1'b1;
                alloc_idx  = SW'(i);
            end
        end
    end

    assign src_haz = (src1_en && pend[src1]) || (src2_en && pend[src2]);
    assign dst_haz = (dst_en || is_load) && pend[dst];

    always_comb begin
        if (!req_valid)                 dec = DEC_IDLE;
        else if (src_haz)               dec = DEC_SRC_HAZ;
        else if (dst_haz)               dec = DEC_DST_HAZ;
        else if (is_load && !free_found) dec = DEC_FULL;
        else if (xlat_miss && |busy)    dec = DEC_XLAT_HOLD;
        else                            dec = DEC_GRANT;
    end

    always_comb begin
        unique case (dec)
            DEC_GRANT: grant = 1'b1;
            DEC_IDLE, DEC_SRC_HAZ, DEC_DST_HAZ,
            DEC_FULL, DEC_XLAT_HOLD: grant = 1'b0;
            default:   grant = 1'b0;
        endcase
        alloc_en = grant && is_load;
    end

    // R3: no grant while a read source is waiting
    p_src_block_r3: assert property (@(posedge clk) disable iff (rst)
        (grant && src1_en) |-> !pend[src1]);

    // R4: no grant onto a waiting destination
    p_dst_block_r4: assert property (@(posedge clk) disable iff (rst)
        (grant && dst_en) |-> !pend[dst]);

    // R2: an allocation always lands on a free slot
    p_alloc_target_r2: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !busy[alloc_idx]);

endmodule

// File: rtl/miss_scoreboard.sv
module miss_scoreboard #(
    parameter int NREG  = 32,
    parameter int NSLOT = 8,
    localparam int RW = $clog2(NREG),
    localparam int SW = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iss_valid,
    input  logic [RW-1:0] iss_src1,
    input  logic          iss_src1_en,
    input  logic [RW-1:0] iss_src2,
    input  logic          iss_src2_en,
    input  logic [RW-1:0] iss_dst,
    input  logic          iss_dst_en,
    input  logic          iss_load,
    input  logic          iss_xlat_miss,
    input  logic          ret_valid,
    input  logic [SW-1:0] ret_slot,
    output logic          iss_grant,
    output logic [SW-1:0] iss_slot
);

    logic [NREG-1:0]  pend;
    logic [NSLOT-1:0] busy;
    logic [RW-1:0]    slot_dst [NSLOT];
    logic             alloc_en;
    logic [SW-1:0]    alloc_idx;
    logic             ret_hit;

    assign ret_hit  = ret_valid && busy[ret_slot];
    assign iss_slot = alloc_idx;

    miss_sb_issue #(.NREG(NREG), .NSLOT(NSLOT)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .req_valid (iss_valid),
        .src1      (iss_src1),
        .src1_en   (iss_src1_en),
        .src2      (iss_src2),
        .src2_en   (iss_src2_en),
        .dst       (iss_dst),
        .dst_en    (iss_dst_en),
        .is_load   (iss_load),
        .xlat_miss (iss_xlat_miss),
        .pend      (pend),
        .busy      (busy),
        .grant     (iss_grant),
        .alloc_en  (alloc_en),
        .alloc_idx (alloc_idx)
    );

    miss_sb_pending #(.NREG(NREG)) u_pending (
        .clk     (clk),
        .rst     (rst),
        .set_en  (alloc_en),
        .set_idx (iss_dst),
        .clr_en  (ret_hit),
        .clr_idx (slot_dst[ret_slot]),
        .pend    (pend)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        miss_sb_slot #(.NREG(NREG)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .alloc     (alloc_en && alloc_idx == SW'(g)),
            .alloc_dst (iss_dst),
            .release_i (ret_hit && ret_slot == SW'(g)),
            .busy      (busy[g]),
            .dst       (slot_dst[g])
        );
    end

    // R7: a translation-miss access issues only with no slot busy
    p_xlat_drain_r7: assert property (@(posedge clk) disable iff (rst)
        (iss_grant && iss_xlat_miss) |-> busy == '0);

    // R6: a full table blocks every load
    p_full_block_r6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_load && &busy) |-> !iss_grant);

    // R1: nothing is busy right after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (busy == '0 && pend == '0));

    // R9: a return leaves other slots untouched
    p_one_release_r9: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !alloc_en) |=> $countones(busy) >= $countones($past(busy)) - 1);

endmodule

// File: tb/miss_scoreboard_bench.sv
module miss_scoreboard_bench;

    localparam int NREG  = 32;
    localparam int NSLOT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_valid = 1'b0;
    logic [4:0] iss_src1 = '0;
    logic       iss_src1_en = 1'b0;
    logic [4:0] iss_src2 = '0;
    logic       iss_src2_en = 1'b0;
    logic [4:0] iss_dst = '0;
    logic       iss_dst_en = 1'b0;
    logic       iss_load = 1'b0;
    logic       iss_xlat_miss = 1'b0;
    logic       ret_valid = 1'b0;
    logic [2:0] ret_slot = '0;
    logic       iss_grant;
    logic [2:0] iss_slot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  grant;
        int    slot;
        bit    use_slot;
        string tag;
    } exp_t;

    exp_t expq[$];

    always #2.5 clk = ~clk;

    miss_scoreboard #(.NREG(NREG), .NSLOT(NSLOT)) u_miss_scoreboard (
        .clk(clk), .rst(rst), .iss_valid(iss_valid),
        .iss_src1(iss_src1), .iss_src1_en(iss_src1_en),
        .iss_src2(iss_src2), .iss_src2_en(iss_src2_en),
        .iss_dst(iss_dst), .iss_dst_en(iss_dst_en),
        .iss_load(iss_load), .iss_xlat_miss(iss_xlat_miss),
        .ret_valid(ret_valid), .ret_slot(ret_slot),
        .iss_grant(iss_grant), .iss_slot(iss_slot)
    );

    always @(negedge clk) begin
        if (expq.size() != 0) begin
            exp_t e;
            e = expq.pop_front();
            checks++;
            if (iss_grant !== e.grant) begin
                errors++;
                $display("FAIL %s: grant=%0b expected %0b", e.tag, iss_grant, e.grant);
            end else if (e.use_slot && iss_slot !== 3'(e.slot)) begin
                errors++;
                $display("FAIL %s: slot=%0d expected %0d", e.tag, iss_slot, e.slot);
            end
        end
    end

    task automatic drive(input logic v, input int s1, input logic s1e,
                         input int d, input logic de, input logic ld,
                         input logic xm, input logic rv, input int rs,
                         input logic eg, input int es, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        iss_valid = v; iss_src1 = 5'(s1); iss_src1_en = s1e;
        iss_src2 = 5'd0; iss_src2_en = 1'b1;
        iss_dst = 5'(d); iss_dst_en = de; iss_load = ld; iss_xlat_miss = xm;
        ret_valid = rv; ret_slot = 3'(rs);
        e.grant = eg; e.slot = es; e.use_slot = eg && ld; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic alu(input int s1, input int d, input logic xm, input logic rv,
                       input int rs, input logic eg, input string tag);
        drive(1'b1, s1, 1'b1, d, 1'b1, 1'b0, xm, rv, rs, eg, 0, tag);
    endtask

    task automatic ld_op(input int d, input logic xm, input logic rv, input int rs,
                         input logic eg, input int es, input string tag);
        drive(1'b1, 1, 1'b1, d, 1'b0, 1'b1, xm, rv, rs, eg, es, tag);
    endtask

    task automatic ret_only(input int rs, input string tag);
        drive(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, rs, 1'b0, 0, tag);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        iss_valid = 1'b0; ret_valid = 1'b0; rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        alu(2, 1, 0, 0, 0, 1, "R1 first op after reset");
        ld_op(5, 0, 0, 0, 1, 0, "R2 load gets slot 0");
        alu(2, 6, 0, 0, 0, 1, "R2 independent op flows");
        alu(5, 7, 0, 0, 0, 0, "R3 read of waiting r5");
        alu(1, 5, 0, 0, 0, 0, "R4 write of waiting r5");
        ld_op(8, 0, 0, 0, 1, 1, "R5 second miss overlaps in slot 1");
        ld_op(9, 1, 0, 0, 0, 0, "R7 xlat load held behind misses");
        alu(8, 3, 0, 1, 1, 0, "R8 same-cycle return still stalls");
        alu(8, 3, 0, 0, 0, 1, "R9 out-of-order slot 1 return frees r8");
        alu(5, 3, 0, 1, 3, 0, "R10 return to free slot 3");
        alu(5, 3, 0, 0, 0, 0, "R10 r5 still waiting after bogus return");
        ld_op(10, 0, 0, 0, 1, 1, "R10 slot 1 reused, table unchanged");
        ret_only(0, "R8 release slot 0");
        alu(5, 4, 0, 0, 0, 1, "R8 r5 readable next cycle");
        ld_op(11, 0, 0, 0, 1, 0, "R5 fill slot 0");
        ld_op(12, 0, 0, 0, 1, 2, "R5 fill slot 2");
        ld_op(13, 0, 0, 0, 1, 3, "R5 fill slot 3");
        ld_op(14, 0, 0, 0, 1, 4, "R5 fill slot 4");
        ld_op(15, 0, 0, 0, 1, 5, "R5 fill slot 5");
        ld_op(16, 0, 0, 0, 1, 6, "R5 fill slot 6");
        ld_op(17, 0, 0, 0, 1, 7, "R5 fill slot 7");
        ld_op(18, 0, 0, 0, 0, 0, "R6 load stalls on full table");
        alu(1, 20, 0, 0, 0, 1, "R6 non-load flows on full table");
        alu(1, 21, 1, 0, 0, 0, "R7 xlat op held with busy slots");
        ld_op(18, 0, 1, 4, 0, 0, "R8 load stalls in release cycle");
        ld_op(18, 0, 0, 0, 1, 4, "R6 load takes freed slot 4");
        for (int s = 0; s < NSLOT; s++) ret_only(s, "R9 drain slot");
        ld_op(22, 1, 0, 0, 1, 0, "R7 xlat load issues when drained");
        alu(22, 23, 0, 0, 0, 0, "R3 read of waiting r22");
        do_reset();
        alu(22, 23, 0, 0, 0, 1, "R1 reset cleared r22 flag");
        ld_op(24, 1, 0, 0, 1, 0, "R1 reset freed all slots");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule